// File: doc/BRIEF.md
# Operand Hazard Detection and Forwarding Unit

This combinational unit sits beside the decode stage of a five-stage, 32-register load/store pipeline. Each cycle it looks at the two source register indices of the instruction in decode. It compares them with the destination of the instruction now in execute and the one now in memory. From that it either supplies the newest value of each source operand, asks the front of the pipeline to freeze for one cycle, or leaves the operands alone.

A two-bit run-time mode picks the policy: detection off, freeze on every dependency, or freeze only on a load-use dependency and forward all other results. A destination of register zero never creates a dependency, because writes to it are discarded. A dependency on the second source field counts only when the producing instruction is register-register or a store. When a freeze is requested, fetch and decode keep their contents and the decode-to-execute latch is cleared so that a nop enters execute. For that reason the freeze request and the bubble request are issued together.

Top module: `hzd_fwd_unit`

## Requirements
- R1: A stage whose write enable is low, or whose destination index is 0, never causes a freeze and never supplies a forwarded value.
- R2: A match between a stage destination and the decode first source index (rs) counts as a dependency whatever the class of the stage instruction.
- R3: A match against the decode second source index (rt) counts only when the stage class code is 0 (register-register) or 3 (store). Class 1 (immediate) and class 2 (jump) never create an rt dependency or an rt forward.
- R4: In mode 2 (forwarding), an execute-stage dependency whose instruction reads memory raises `stall_o`.
- R5: In mode 2, an execute-stage dependency with no memory read raises no freeze. The execute result replaces each matching operand, and both operands can be replaced in the same cycle.
- R6: In mode 2, a memory-stage dependency supplies the memory-stage write-back value with no freeze. When both stages match the same operand, the execute result wins, unless the execute instruction reads memory.
- R7: In mode 1 (freeze only), any dependency on either stage raises `stall_o`, and both operand outputs equal the decode values.
- R8: In mode 0 (off) and in the reserved mode 3, `stall_o` is 0 and both operand outputs equal the decode values.
- R9: `bubble_o` equals `stall_o` in every case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | 0 off, 1 freeze only, 2 freeze and forward, 3 reserved (off) |
| dec_rs_idx_i | input | 5 | Decode first source index |
| dec_rt_idx_i | input | 5 | Decode second source index |
| dec_rs_val_i | input | 32 | Register file value for rs |
| dec_rt_val_i | input | 32 | Register file value for rt |
| ex_wr_en_i | input | 1 | Execute instruction writes a register |
| ex_dest_i | input | 5 | Execute destination index |
| ex_class_i | input | 2 | Execute class: 0 reg-reg, 1 immediate, 2 jump, 3 store |
| ex_mem_rd_i | input | 1 | Execute instruction is a load |
| ex_result_i | input | 32 | Execute ALU result |
| mem_wr_en_i | input | 1 | Memory-stage instruction writes a register |
| mem_dest_i | input | 5 | Memory-stage destination index |
| mem_class_i | input | 2 | Memory-stage class, same codes |
| mem_result_i | input | 32 | Memory-stage write-back value (load data or ALU result) |
| rs_val_o | output | 32 | Resolved rs operand |
| rt_val_o | output | 32 | Resolved rt operand |
| stall_o | output | 1 | Freeze fetch and decode |
| bubble_o | output | 1 | Clear the decode-to-execute latch |

## Verification
The assertions check four rules on every input combination. Register-zero and disabled writes stay invisible. The off and freeze-only modes pass operands through untouched. A load-use match in forwarding mode always freezes. A non-load execute stage never freezes in forwarding mode. What the assertions cannot show is which value wins when both stages match. They also cannot show that the class qualifier suppresses only the rt path while the rs path still fires. The bench's directed scenarios cover these, including the case where a load in execute hands priority back to the memory stage.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_STALL  = 2'd1,
    MODE_FWD    = 2'd2,
    MODE_RSVD   = 2'd3
  } hzd_mode_e;

  typedef enum logic [1:0] {
    CLS_REG   = 2'd0,
    CLS_IMM   = 2'd1,
    CLS_JMP   = 2'd2,
    CLS_STORE = 2'd3
  } ins_class_e;

  localparam int N_STAGES = 2;
  localparam int ST_EX    = 0;
  localparam int ST_MEM   = 1;
endpackage

// File: rtl/hzd_stage_match.sv
module hzd_stage_match
  import hzd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] dest_i,
  input  logic [1:0]       class_i,
  input  logic [IDX_W-1:0] rs_idx_i,
  input  logic [IDX_W-1:0] rt_idx_i,
  output logic             rs_hit_o,
  output logic             rt_hit_o
);
  logic       live;
  logic       rt_qual;
  ins_class_e cls;

  always_comb begin
    cls      = ins_class_e'(class_i);
    live     = wr_en_i && (dest_i != '0);
    rt_qual  = (cls == CLS_REG) || (cls == CLS_STORE);
    rs_hit_o = live && (dest_i == rs_idx_i);
    rt_hit_o = live && rt_qual && (dest_i == rt_idx_i);
  end
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       ex_rs_hit_i,
  input  logic       ex_rt_hit_i,
  input  logic       mem_rs_hit_i,
  input  logic       mem_rt_hit_i,
  input  logic       ex_mem_rd_i,
  output logic       fwd_en_o,
  output logic       stall_o
);
  hzd_mode_e mode;
  logic      ex_any;
  logic      any_hit;

  always_comb begin
    mode    = hzd_mode_e'(mode_i);
    ex_any  = ex_rs_hit_i | ex_rt_hit_i;
    any_hit = ex_any | mem_rs_hit_i | mem_rt_hit_i;
    fwd_en_o = 1'b0;
    stall_o  = 1'b0;
    case (mode)
      MODE_STALL: stall_o = any_hit;
      MODE_FWD: begin
        fwd_en_o = 1'b1;
        stall_o  = ex_any & ex_mem_rd_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel #(
  parameter int DATA_W = 32
) (
  input  logic              fwd_en_i,
  input  logic [DATA_W-1:0] dec_val_i,
  input  logic              ex_hit_i,
  input  logic              ex_ok_i,
  input  logic [DATA_W-1:0] ex_val_i,
  input  logic              mem_hit_i,
  input  logic [DATA_W-1:0] mem_val_i,
  output logic [DATA_W-1:0] val_o
);
  always_comb begin
    val_o = dec_val_i;
    if (fwd_en_i) begin
      if (ex_hit_i && ex_ok_i) val_o = ex_val_i;
      else if (mem_hit_i)      val_o = mem_val_i;
    end
  end
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [1:0]        mode_i,
  input  logic [IDX_W-1:0]  dec_rs_idx_i,
  input  logic [IDX_W-1:0]  dec_rt_idx_i,
  input  logic [DATA_W-1:0] dec_rs_val_i,
  input  logic [DATA_W-1:0] dec_rt_val_i,
  input  logic              ex_wr_en_i,
  input  logic [IDX_W-1:0]  ex_dest_i,
  input  logic [1:0]        ex_class_i,
  input  logic              ex_mem_rd_i,
  input  logic [DATA_W-1:0] ex_result_i,
  input  logic              mem_wr_en_i,
  input  logic [IDX_W-1:0]  mem_dest_i,
  input  logic [1:0]        mem_class_i,
  input  logic [DATA_W-1:0] mem_result_i,
  output logic [DATA_W-1:0] rs_val_o,
  output logic [DATA_W-1:0] rt_val_o,
  output logic              stall_o,
  output logic              bubble_o
);
  localparam int N_OPS = 2;

  logic              st_wr   [N_STAGES];
  logic [IDX_W-1:0]  st_dest [N_STAGES];
  logic [1:0]        st_cls  [N_STAGES];
  logic              rs_hit  [N_STAGES];
  logic              rt_hit  [N_STAGES];
  logic [DATA_W-1:0] op_dec  [N_OPS];
  logic [DATA_W-1:0] op_out  [N_OPS];
  logic              op_exh  [N_OPS];
  logic              op_memh [N_OPS];
  logic              fwd_en;
  logic              stall_w;

  always_comb begin
    st_wr[ST_EX]    = ex_wr_en_i;
    st_dest[ST_EX]  = ex_dest_i;
    st_cls[ST_EX]   = ex_class_i;
    st_wr[ST_MEM]   = mem_wr_en_i;
    st_dest[ST_MEM] = mem_dest_i;
    st_cls[ST_MEM]  = mem_class_i;
    op_dec[0]  = dec_rs_val_i;
    op_dec[1]  = dec_rt_val_i;
    op_exh[0]  = rs_hit[ST_EX];
    op_exh[1]  = rt_hit[ST_EX];
    op_memh[0] = rs_hit[ST_MEM];
    op_memh[1] = rt_hit[ST_MEM];
  end

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    hzd_stage_match #(.IDX_W(IDX_W)) u_match (
      .wr_en_i (st_wr[s]),
      .dest_i  (st_dest[s]),
      .class_i (st_cls[s]),
      .rs_idx_i(dec_rs_idx_i),
      .rt_idx_i(dec_rt_idx_i),
      .rs_hit_o(rs_hit[s]),
      .rt_hit_o(rt_hit[s])
    );
  end

  hzd_ctrl u_ctrl (
    .mode_i      (mode_i),
    .ex_rs_hit_i (rs_hit[ST_EX]),
    .ex_rt_hit_i (rt_hit[ST_EX]),
    .mem_rs_hit_i(rs_hit[ST_MEM]),
    .mem_rt_hit_i(rt_hit[ST_MEM]),
    .ex_mem_rd_i (ex_mem_rd_i),
    .fwd_en_o    (fwd_en),
    .stall_o     (stall_w)
  );

  for (genvar o = 0; o < N_OPS; o++) begin : g_op
    hzd_fwd_sel #(.DATA_W(DATA_W)) u_sel (
      .fwd_en_i (fwd_en),
      .dec_val_i(op_dec[o]),
      .ex_hit_i (op_exh[o]),
      .ex_ok_i  (!ex_mem_rd_i),
      .ex_val_i (ex_result_i),
      .mem_hit_i(op_memh[o]),
      .mem_val_i(mem_result_i),
      .val_o    (op_out[o])
    );
  end

  always_comb begin
    rs_val_o = op_out[0];
    rt_val_o = op_out[1];
    stall_o  = stall_w;
    bubble_o = stall_w;
  end

  // Port-level checks on the assembled outputs of the sub-blocks.
  always_comb begin
    // R1: nothing live in either stage -> transparent, no freeze
    if ((!ex_wr_en_i || ex_dest_i == '0) && (!mem_wr_en_i || mem_dest_i == '0))
      p_dead_stages_r1: assert (!stall_o && rs_val_o == dec_rs_val_i && rt_val_o == dec_rt_val_i);
    // R8: off / reserved mode passes through
    if (mode_i == 2'd0 || mode_i == 2'd3)
      p_mode_off_r8: assert (!stall_o && rs_val_o == dec_rs_val_i && rt_val_o == dec_rt_val_i);
    // R7: freeze-only mode never alters operands
    if (mode_i == 2'd1)
      p_no_fwd_stall_mode_r7: assert (rs_val_o == dec_rs_val_i && rt_val_o == dec_rt_val_i);
    // R4: load-use on rs in forwarding mode must freeze
    if (mode_i == 2'd2 && ex_mem_rd_i && ex_wr_en_i && ex_dest_i != '0 && ex_dest_i == dec_rs_idx_i)
      p_load_use_r4: assert (stall_o && bubble_o);
    // R5: a non-load execute stage never freezes in forwarding mode
    if (mode_i == 2'd2 && !ex_mem_rd_i)
      p_fwd_no_stall_r5: assert (!stall_o);
  end
endmodule

// File: tb/hzd_fwd_unit_tb_top.sv
module hzd_fwd_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  CLS_R = 0, CLS_I = 1, CLS_J = 2, CLS_S = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode;
  logic [4:0]  rs_idx, rt_idx, ex_dest, mem_dest;
  logic [31:0] rs_val, rt_val, ex_res, mem_res;
  logic        ex_wr, ex_rd, mem_wr;
  logic [1:0]  ex_cls, mem_cls;
  logic [31:0] rs_o, rt_o;
  logic        stall, bubble;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hzd_fwd_unit dut_i (
    .mode_i(mode), .dec_rs_idx_i(rs_idx), .dec_rt_idx_i(rt_idx),
    .dec_rs_val_i(rs_val), .dec_rt_val_i(rt_val),
    .ex_wr_en_i(ex_wr), .ex_dest_i(ex_dest), .ex_class_i(ex_cls),
    .ex_mem_rd_i(ex_rd), .ex_result_i(ex_res),
    .mem_wr_en_i(mem_wr), .mem_dest_i(mem_dest), .mem_class_i(mem_cls),
    .mem_result_i(mem_res),
    .rs_val_o(rs_o), .rt_val_o(rt_o), .stall_o(stall), .bubble_o(bubble)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle(input logic [1:0] m);
    mode = m; rs_idx = 5'd1; rt_idx = 5'd2;
    rs_val = 32'h1111_0001; rt_val = 32'h2222_0002;
    ex_wr = 0; ex_dest = 0; ex_cls = 2'(CLS_R); ex_rd = 0; ex_res = 32'hEEEE_0000;
    mem_wr = 0; mem_dest = 0; mem_cls = 2'(CLS_R); mem_res = 32'hDDDD_0000;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic expect_out(input string req, input logic [31:0] ers, input logic [31:0] ert, input logic est);
    check(req, "rs_val", rs_o, ers);
    check(req, "rt_val", rt_o, ert);
    check(req, "stall", {31'd0, stall}, {31'd0, est});
    check("R9", "bubble", {31'd0, bubble}, {31'd0, stall});
  endtask

  task automatic t_reset_idle();
    idle(2'd2); settle();
    expect_out("R1", 32'h1111_0001, 32'h2222_0002, 1'b0);
  endtask

  task automatic t_zero_dest();
    idle(2'd2); rs_idx = 0; rt_idx = 0;
    ex_wr = 1; ex_dest = 0; mem_wr = 1; mem_dest = 0; settle();
    expect_out("R1", 32'h1111_0001, 32'h2222_0002, 1'b0);
    idle(2'd1); ex_wr = 0; ex_dest = 5'd1; settle();
    expect_out("R1", 32'h1111_0001, 32'h2222_0002, 1'b0);
  endtask

  task automatic t_back_to_back_alu();
    idle(2'd2); ex_wr = 1; ex_dest = 5'd1; settle();
    expect_out("R5", 32'hEEEE_0000, 32'h2222_0002, 1'b0);
    rt_idx = 5'd1; settle();
    expect_out("R5", 32'hEEEE_0000, 32'hEEEE_0000, 1'b0);
  endtask

  task automatic t_rt_qualifier();
    idle(2'd2); ex_wr = 1; ex_dest = 5'd2; ex_cls = 2'(CLS_I); settle();
    expect_out("R3", 32'h1111_0001, 32'h2222_0002, 1'b0);
    ex_cls = 2'(CLS_J); settle();
    expect_out("R3", 32'h1111_0001, 32'h2222_0002, 1'b0);
    ex_cls = 2'(CLS_S); settle();
    expect_out("R3", 32'h1111_0001, 32'hEEEE_0000, 1'b0);
    idle(2'd1); ex_wr = 1; ex_dest = 5'd2; ex_cls = 2'(CLS_I); settle();
    expect_out("R3", 32'h1111_0001, 32'h2222_0002, 1'b0);
    idle(2'd2); ex_wr = 1; ex_dest = 5'd1; ex_cls = 2'(CLS_I); rt_idx = 5'd1; settle();
    expect_out("R2", 32'hEEEE_0000, 32'h2222_0002, 1'b0);
  endtask

  task automatic t_load_use();
    idle(2'd2); ex_wr = 1; ex_dest = 5'd1; ex_cls = 2'(CLS_I); ex_rd = 1;
    mem_wr = 1; mem_dest = 5'd1; settle();
    check("R4", "stall", {31'd0, stall}, 32'd1);
    check("R6", "rs_val after load in ex", rs_o, 32'hDDDD_0000);
    check("R9", "bubble", {31'd0, bubble}, 32'd1);
  endtask

  task automatic t_mem_forward();
    idle(2'd2); mem_wr = 1; mem_dest = 5'd2; mem_res = 32'hCAFE_0042; settle();
    expect_out("R6", 32'h1111_0001, 32'hCAFE_0042, 1'b0);
    ex_wr = 1; ex_dest = 5'd2; settle();
    expect_out("R6", 32'h1111_0001, 32'hEEEE_0000, 1'b0);
  endtask

  task automatic t_stall_only();
    idle(2'd1); mem_wr = 1; mem_dest = 5'd1; settle();
    expect_out("R7", 32'h1111_0001, 32'h2222_0002, 1'b1);
    idle(2'd1); ex_wr = 1; ex_dest = 5'd2; settle();
    expect_out("R7", 32'h1111_0001, 32'h2222_0002, 1'b1);
  endtask

  task automatic t_mode_off();
    for (int m = 0; m < 4; m += 3) begin
      idle(2'(m)); ex_wr = 1; ex_dest = 5'd1; ex_rd = 1; mem_wr = 1; mem_dest = 5'd2; settle();
      expect_out("R8", 32'h1111_0001, 32'h2222_0002, 1'b0);
    end
  endtask

  initial begin
    idle(2'd0);
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_reset_idle();
    t_zero_dest();
    t_back_to_back_alu();
    t_rt_qualifier();
    t_load_use();
    t_mem_forward();
    t_stall_only();
    t_mode_off();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule